// File: doc/BRIEF.md
# Frame Writeback Sequencer

This block is the control side of a display writeback engine that captures one composited frame into memory. Software programs a destination address, a line pitch and the frame size through a small word-addressed register bus, then sets a start bit in the control word. The sequencer marks itself busy and emits a one-cycle frame-start pulse. It then counts the lines that the memory path reports as committed. When the count reaches the programmed height, it returns to idle. Being idle raises the interrupt if it is enabled.

An abort command ends the frame in flight at once and withdraws the write permission given to the memory path. A power-down bit is passed to the internal memory. An option makes the sequencer emit a second frame-start pulse at the end of each frame. The control word has fixed identification bits that no write changes. The pixel formatter and the bus master that writes memory are outside this block. The block talks to them only through the `line_commit` strobe and the `wr_allow`, `frame_start` and configuration outputs.

Top module: `wbk_seq`

## Requirements
- R1: Writes with `bus_wr_en` high to byte address 0x00 (destination), 0x04 (pitch) or 0x08 (size: height in bits [31:16], width in bits [15:0]) are stored while idle. They read back combinationally on `bus_rdata` and appear on the `cfg_*` outputs. Writes to 0x10 or to unaligned addresses change nothing.
- R2: While busy (control bit 1 = 1), writes to 0x00, 0x04 and 0x08 are ignored.
- R3: The control word at 0x0C always reads bits [31:24] = 0x54 and [23:22] = 01. The start bit 0 and abort bit 14 always read 0. Bits [21:15] and [13:2] read back as last written.
- R4: A control write with bit 0 = 1, made while idle and not powered down, starts a frame. After that clock edge, busy reads 1, progress (0x10) reads 0 and `frame_start` is high for exactly one cycle.
- R5: A start request made while busy, or while power-down (bit 21) is set before the write, is ignored and produces no `frame_start` pulse.
- R6: Each cycle with `line_commit` high while busy raises progress by one, up to the height. `line_commit` while idle leaves progress unchanged.
- R7: On the edge after progress equals the height, busy clears and progress holds. A frame with height 0 ends one cycle after it starts.
- R8: With control bit 15 set, `frame_start` pulses for one cycle as busy clears at normal completion. With bit 15 clear, it does not.
- R9: A control write with bit 14 = 1 while busy clears busy and `wr_allow` on that edge. Progress is kept and there is no end-of-frame pulse.
- R10: `irq` is high exactly when control bit 2 is set and the block is idle. Writing bit 2 as 0 clears it.
- R11: `mem_pwrdn` follows control bit 21.
- R12: After reset, all registers read 0 except the control word, which reads 0x5440_0000, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| line_commit | input | 1 | One line committed to memory |
| frame_start | output | 1 | One-cycle frame-start pulse |
| irq | output | 1 | Idle interrupt |
| wr_allow | output | 1 | Memory writes permitted (frame in flight) |
| mem_pwrdn | output | 1 | Internal memory power-down |
| cfg_ptr | output | 32 | Destination address |
| cfg_pitch | output | 32 | Line pitch in bytes |
| cfg_width | output | 16 | Frame width |
| cfg_height | output | 16 | Frame height in lines |

## Verification
Every cycle, the assertions check the following. The configuration outputs stay frozen while busy. The identification bits are present whenever the control word is addressed. A rising busy always comes with a frame-start pulse. Progress moves by at most one per cycle and never passes the height. The interrupt is never high while busy. The bench scenarios are needed to show the rest. These are: the exact cycle of completion and of the optional end-of-frame pulse, the effect of abort on progress and on pulses, start requests refused under power-down, and height-zero frames.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned DIM_W = 16;
  localparam int unsigned NCFG  = 3;

  typedef enum logic [2:0] {
    IDX_PTR   = 3'd0,
    IDX_PITCH = 3'd1,
    IDX_SIZE  = 3'd2,
    IDX_CTRL  = 3'd3,
    IDX_PROG  = 3'd4
  } reg_idx_e;

  localparam int unsigned B_GO     = 0;
  localparam int unsigned B_BUSY   = 1;
  localparam int unsigned B_IRQEN  = 2;
  localparam int unsigned B_ABORT  = 14;
  localparam int unsigned B_EOFSTR = 15;
  localparam int unsigned B_PWRDN  = 21;

  localparam logic [7:0]       ID_HI     = 8'h54;
  localparam logic [1:0]       ID_LO     = 2'b01;
  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h003F_BFFC;
endpackage

// File: rtl/wbk_cfg_regs.sv
module wbk_cfg_regs
  import wbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCFG-1:0]  cfg_wsel,
  input  logic             ctrl_wsel,
  input  logic             busy,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cfg_q [NCFG],
  output logic [REG_W-1:0] ctrl_q
);
  genvar k;
  generate
    for (k = 0; k < NCFG; k++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cfg_q[k] <= '0;
        else if (cfg_wsel[k] && !busy) cfg_q[k] <= wdata;
      end
    end
  endgenerate

  // Control settings may change at any time; start/abort/busy are not stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_wsel) ctrl_q <= wdata & CTRL_KEEP;
  end
endmodule

// File: rtl/wbk_frame_seq.sv
module wbk_frame_seq
  import wbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             abort_req,
  input  logic             pwrdn,
  input  logic             eof_start_en,
  input  logic [DIM_W-1:0] height,
  input  logic             line_commit,
  output logic             busy,
  output logic [DIM_W-1:0] progress,
  output logic             frame_start
);
  logic accept, at_end;
  assign accept = go_req && !busy && !pwrdn;
  assign at_end = busy && (progress == height);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      progress    <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (accept) begin
        busy        <= 1'b1;
        progress    <= '0;
        frame_start <= 1'b1;
      end else if (busy) begin
        if (abort_req) begin
          busy <= 1'b0;
        end else if (at_end) begin
          busy        <= 1'b0;
          frame_start <= eof_start_en;
        end else if (line_commit) begin
          progress <= progress + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wbk_seq.sv
module wbk_seq
  import wbk_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              line_commit,
  output logic              frame_start,
  output logic              irq,
  output logic              wr_allow,
  output logic              mem_pwrdn,
  output logic [REG_W-1:0]  cfg_ptr,
  output logic [REG_W-1:0]  cfg_pitch,
  output logic [DIM_W-1:0]  cfg_width,
  output logic [DIM_W-1:0]  cfg_height
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             aligned;
  logic [NCFG-1:0]  cfg_wsel;
  logic             ctrl_wsel;
  logic [REG_W-1:0] cfg_q [NCFG];
  logic [REG_W-1:0] ctrl_q;
  logic             busy;
  logic [DIM_W-1:0] progress;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  genvar k;
  generate
    for (k = 0; k < NCFG; k++) begin : g_sel
      assign cfg_wsel[k] = bus_wr_en && aligned && (widx == IDX_W'(k));
    end
  endgenerate
  assign ctrl_wsel = bus_wr_en && aligned && (widx == IDX_W'(IDX_CTRL));

  wbk_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wsel  (cfg_wsel),
    .ctrl_wsel (ctrl_wsel),
    .busy      (busy),
    .wdata     (bus_wdata),
    .cfg_q     (cfg_q),
    .ctrl_q    (ctrl_q)
  );

  wbk_frame_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_req       (ctrl_wsel && bus_wdata[B_GO]),
    .abort_req    (ctrl_wsel && bus_wdata[B_ABORT]),
    .pwrdn        (ctrl_q[B_PWRDN]),
    .eof_start_en (ctrl_q[B_EOFSTR]),
    .height       (cfg_height),
    .line_commit  (line_commit),
    .busy         (busy),
    .progress     (progress),
    .frame_start  (frame_start)
  );

  assign cfg_ptr    = cfg_q[IDX_PTR];
  assign cfg_pitch  = cfg_q[IDX_PITCH];
  assign cfg_width  = cfg_q[IDX_SIZE][DIM_W-1:0];
  assign cfg_height = cfg_q[IDX_SIZE][REG_W-1:DIM_W];
  assign irq        = ctrl_q[B_IRQEN] && !busy;
  assign wr_allow   = busy;
  assign mem_pwrdn  = ctrl_q[B_PWRDN];

  logic [REG_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd         = ctrl_q;
    ctrl_rd[31:24]  = ID_HI;
    ctrl_rd[23:22]  = ID_LO;
    ctrl_rd[B_BUSY] = busy;
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (widx)
        IDX_W'(IDX_PTR):   bus_rdata = cfg_q[IDX_PTR];
        IDX_W'(IDX_PITCH): bus_rdata = cfg_q[IDX_PITCH];
        IDX_W'(IDX_SIZE):  bus_rdata = cfg_q[IDX_SIZE];
        IDX_W'(IDX_CTRL):  bus_rdata = ctrl_rd;
        IDX_W'(IDX_PROG):  bus_rdata = REG_W'(progress);
        default:           bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wbk_seq_chk.sv
module wbk_seq_chk
  import wbk_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [DIM_W-1:0]  progress,
  input logic [DIM_W-1:0]  cfg_height,
  input logic [DIM_W-1:0]  cfg_width,
  input logic [REG_W-1:0]  cfg_ptr,
  input logic [REG_W-1:0]  cfg_pitch,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              frame_start,
  input logic              irq
);
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_ptr) && $stable(cfg_pitch) && $stable(cfg_width) && $stable(cfg_height)));

  p_id_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(12)) |-> (bus_rdata[31:22] == 10'h151 && !bus_rdata[0] && !bus_rdata[14]));

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> frame_start);

  p_prog_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (progress == $past(progress) || progress == DIM_W'($past(progress) + 1'b1)));

  p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (progress <= cfg_height));

  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

bind wbk_seq wbk_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .progress    (progress),
  .cfg_height  (cfg_height),
  .cfg_width   (cfg_width),
  .cfg_ptr     (cfg_ptr),
  .cfg_pitch   (cfg_pitch),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .frame_start (frame_start),
  .irq         (irq)
);

// File: tb/wbk_seq_tb.sv
module wbk_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        line_commit = 1'b0;
  logic        frame_start, irq, wr_allow, mem_pwrdn;
  logic [31:0] cfg_ptr, cfg_pitch;
  logic [15:0] cfg_width, cfg_height;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wbk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_commit(line_commit),
    .frame_start(frame_start), .irq(irq), .wr_allow(wr_allow), .mem_pwrdn(mem_pwrdn),
    .cfg_ptr(cfg_ptr), .cfg_pitch(cfg_pitch), .cfg_width(cfg_width), .cfg_height(cfg_height)
  );

  // {address, write data, expected read-back}
  localparam logic [68:0] VEC [7] = '{
    {5'h00, 32'h1000_0040, 32'h1000_0040},
    {5'h04, 32'h0000_0F00, 32'h0000_0F00},
    {5'h08, 32'h0003_0002, 32'h0003_0002},
    {5'h0C, 32'hFFFF_BFFE, 32'h547F_BFFC},
    {5'h0C, 32'h0000_8004, 32'h5440_8004},
    {5'h10, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h01, 32'h0BAD_0BAD, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic commit();
    line_commit = 1'b1;
    @(posedge clk); @(negedge clk);
    line_commit = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(5'h00, d); chk("R12 ptr", d, 0);
    rd(5'h04, d); chk("R12 pitch", d, 0);
    rd(5'h08, d); chk("R12 size", d, 0);
    rd(5'h0C, d); chk("R12 ctrl", d, 32'h5440_0000);
    rd(5'h10, d); chk("R12 progress", d, 0);
    chk("R12 outputs", {28'd0, frame_start, irq, wr_allow, mem_pwrdn}, 0);

    // R1 R3 register table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], d);
      chk("R1 R3 table", d, VEC[i][31:0]);
    end
    chk("R1 cfg outputs", {cfg_height, cfg_width}, 32'h0003_0002);
    chk("R10 irq idle", {31'd0, irq}, 1);

    // R4 start, frame height 3 with end pulse
    wr(5'h0C, 32'h0000_8005);
    chk("R4 frame_start", {31'd0, frame_start}, 1);
    rd(5'h0C, d); chk("R4 busy", d, 32'h5440_8006);
    rd(5'h10, d); chk("R4 progress", d, 0);
    chk("R10 irq busy", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R4 one cycle", {31'd0, frame_start}, 0);
    wr(5'h00, 32'hDEAD_0000);
    rd(5'h00, d); chk("R2 ptr frozen", d, 32'h1000_0040);
    wr(5'h08, 32'h0009_0009);
    chk("R2 size frozen", {cfg_height, cfg_width}, 32'h0003_0002);
    wr(5'h0C, 32'h0000_8005);
    chk("R5 go while busy", {31'd0, frame_start}, 0);
    commit(); commit();
    rd(5'h10, d); chk("R6 progress 2", d, 2);
    commit();
    rd(5'h10, d); chk("R6 progress 3", d, 3);
    chk("R7 still busy", {31'd0, wr_allow}, 1);
    @(negedge clk);
    chk("R7 done", {31'd0, wr_allow}, 0);
    chk("R8 eof pulse", {31'd0, frame_start}, 1);
    chk("R10 irq done", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R8 eof one cycle", {31'd0, frame_start}, 0);
    commit();
    rd(5'h10, d); chk("R6 idle commit", d, 3);

    // R7 R8 height 0, no end pulse
    wr(5'h0C, 32'h0000_0004);
    wr(5'h08, 32'h0000_0005);
    wr(5'h0C, 32'h0000_0005);
    chk("R7 h0 busy", {31'd0, wr_allow}, 1);
    @(negedge clk);
    chk("R7 h0 ended", {31'd0, wr_allow}, 0);
    chk("R8 no eof", {31'd0, frame_start}, 0);

    // R9 abort
    wr(5'h08, 32'h0003_0002);
    wr(5'h0C, 32'h0000_8005);
    commit();
    wr(5'h0C, 32'h0000_C004);
    chk("R9 abort busy", {31'd0, wr_allow}, 0);
    rd(5'h10, d); chk("R9 abort progress", d, 1);
    @(negedge clk);
    chk("R9 no pulse", {31'd0, frame_start}, 0);

    // R10 irq clear
    wr(5'h0C, 32'h0);
    chk("R10 irq clear", {31'd0, irq}, 0);

    // R11 R5 power-down
    wr(5'h0C, 32'h0020_0000);
    chk("R11 pwrdn", {31'd0, mem_pwrdn}, 1);
    wr(5'h0C, 32'h0020_0001);
    chk("R5 go pwrdn", {30'd0, wr_allow, frame_start}, 0);
    wr(5'h0C, 32'h0);
    chk("R11 pwrup", {31'd0, mem_pwrdn}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule